// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor as two requests: a normal request and a fast request. Each source has an enable bit, a type bit that steers it to one of the two requests, a force bit that raises it from software, and a 4-bit priority level. Software sees everything through a small register bus with a 7-bit byte address, 32-bit write data, a write strobe, a read strobe and 32-bit read data.

For the normal request the controller picks one winner. It is the pending normal source with the greatest priority level, among those whose level is above a programmable threshold. Ties go to the higher source number. The winner's number and level appear in the normal vector register. A service routine reads that register until it shows the empty code. The fast path reports the highest-numbered fast-pending source in its own vector register. Nothing is cleared by reading. A request goes away only when its line drops, its force bit is cleared or its enable bit is cleared.

Register writes take effect on the clock edge that samples the write strobe. The pending state, the vectors and both requests follow from the registers and the source lines through combinational logic only.

Top module: `intc_top`

## Requirements
- R1: After reset the outputs and registers hold these values. Control is 0. Threshold (0x04) is 0x1F. All enable, type, force and priority bits are 0. Both vector registers read 0xFFFF0000. nirq and firq are 0.
- R2: Enable, type and force words are each split in two. The low word holds sources 0..31 at bit n. The high word holds sources 32..63 at bit n-32. The addresses are: enable high 0x10 and low 0x14, type high 0x18 and low 0x1C, force high 0x50 and low 0x54. The control register at 0x00 stores 32 bits. Each of these registers reads back the value last written.
- R3: Writing a number 0..63 to 0x08 sets that source's enable bit. Writing a number 0..63 to 0x0C clears it. Values of 64 or more have no effect. Both addresses read as 0.
- R4: Priority register n (n = 0..7) sits at byte address 0x20 + 4*(7-n). It holds sources 8n..8n+7. Source 8n+k uses bits 4k+3:4k. Each priority register reads back the value written.
- R5: A source requests when (line OR force bit) AND enable bit. The normal pending words are 0x58 (high) and 0x5C (low): requests with type 0. The fast pending words are 0x60 (high) and 0x64 (low): requests with type 1. The raw line words are 0x48 (high) and 0x4C (low).
- R6: The normal vector register at 0x40 considers normal-pending sources whose level is strictly greater than the threshold. Among them it picks the highest level, and on equal levels the higher source number. Bits 31:16 hold the source number and bits 15:0 hold its level. With no such source the register reads 0xFFFF0000.
- R7: The threshold register keeps only bits 4:0, and its other bits read 0. The value 0x1F keeps nirq low whatever is pending.
- R8: nirq is 1 exactly when the normal vector holds a source. firq is 1 exactly when any fast-pending bit is set.
- R9: The fast vector register at 0x44 holds the highest-numbered fast-pending source in bits 31:16, with bits 15:0 at 0. With none pending it reads 0xFFFF0000.
- R10: Reading a vector register changes nothing: repeated reads return the same value. A vector goes away when its line is deasserted.
- R11: Addresses outside the map read 0, and writes to read-only registers have no effect. bus_rdata is 0 while bus_re is low.
- R12: A register write shows its effect in the cycle after the clock edge that samples bus_we. A change on a source line reaches the pending state, the vectors, nirq and firq in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 64 | Level-sensitive interrupt lines, bit n is source n |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_re | input | 1 | Read strobe, gates bus_rdata combinationally |
| bus_rdata | output | 32 | Read data, 0 while bus_re is low |
| nirq | output | 1 | Normal interrupt request |
| firq | output | 1 | Fast interrupt request |

## Verification
Writes are due one edge after bus_we is sampled. The bench therefore drives each write from a falling edge and reads only after the following falling edge, once the write edge has passed. Source lines, pending words, vectors and both requests have zero latency. The bench samples them 1 ns after driving, inside the same cycle. For R12 it reads nirq both before and after the write edge, to show that the output does not move early. The sweeps and the randomized patterns compare every vector and pending word against a scan model kept in the bench, which is built from the values the bench wrote.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC      = 64;
    localparam int WORD      = 32;
    localparam int PRIO_W    = 4;
    localparam int ADDR_W    = 7;
    localparam int MASK_W    = 5;
    localparam int ID_W      = $clog2(NSRC);
    localparam int NPRIO_REG = NSRC * PRIO_W / WORD;
    localparam int HALF      = WORD / 2;

    localparam logic [ADDR_W-1:0] A_CTL    = 7'h00;
    localparam logic [ADDR_W-1:0] A_THR    = 7'h04;
    localparam logic [ADDR_W-1:0] A_ENSET  = 7'h08;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 7'h0C;
    localparam logic [ADDR_W-1:0] A_ENHI   = 7'h10;
    localparam logic [ADDR_W-1:0] A_ENLO   = 7'h14;
    localparam logic [ADDR_W-1:0] A_TYHI   = 7'h18;
    localparam logic [ADDR_W-1:0] A_TYLO   = 7'h1C;
    localparam logic [ADDR_W-1:0] A_PRIO0  = 7'h20;
    localparam logic [ADDR_W-1:0] A_NVEC   = 7'h40;
    localparam logic [ADDR_W-1:0] A_FVEC   = 7'h44;
    localparam logic [ADDR_W-1:0] A_RAWHI  = 7'h48;
    localparam logic [ADDR_W-1:0] A_RAWLO  = 7'h4C;
    localparam logic [ADDR_W-1:0] A_FRCHI  = 7'h50;
    localparam logic [ADDR_W-1:0] A_FRCLO  = 7'h54;
    localparam logic [ADDR_W-1:0] A_NPHI   = 7'h58;
    localparam logic [ADDR_W-1:0] A_NPLO   = 7'h5C;
    localparam logic [ADDR_W-1:0] A_FPHI   = 7'h60;
    localparam logic [ADDR_W-1:0] A_FPLO   = 7'h64;

    localparam logic [HALF-1:0]   NO_VEC   = '1;
    localparam logic [MASK_W-1:0] THR_RST  = '1;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] lvl;
    } win_t;

    // priority window lies between the first priority slot and the vector registers
    function automatic logic is_prio_addr(input logic [ADDR_W-1:0] a);
        return (a >= A_PRIO0) && (a < A_NVEC) && (a[1:0] == 2'b00);
    endfunction

    // slots are laid out highest register first
    function automatic logic [2:0] prio_slot(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] d;
        d = a - A_PRIO0;
        return 3'(NPRIO_REG - 1) - d[4:2];
    endfunction

    function automatic logic [WORD-1:0] vec_word(input win_t w);
        if (w.valid)
            return {HALF'(w.id), HALF'(w.lvl)};
        return {NO_VEC, {HALF{1'b0}}};
    endfunction
endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD-1:0]          wdata,
    output logic [WORD-1:0]          ctl_q,
    output logic [MASK_W-1:0]        thr_q,
    output logic [NSRC-1:0]          en_q,
    output logic [NSRC-1:0]          typ_q,
    output logic [NSRC-1:0]          frc_q,
    output logic [NSRC*PRIO_W-1:0]   prio_q
);
    logic num_ok;
    assign num_ok = (wdata < WORD'(NSRC));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            thr_q  <= THR_RST;
            en_q   <= '0;
            typ_q  <= '0;
            frc_q  <= '0;
            prio_q <= '0;
        end else if (we) begin
            case (addr)
                A_CTL:   ctl_q <= wdata;
                A_THR:   thr_q <= wdata[MASK_W-1:0];
                A_ENSET: if (num_ok) en_q[wdata[ID_W-1:0]] <= 1'b1;
                A_ENCLR: if (num_ok) en_q[wdata[ID_W-1:0]] <= 1'b0;
                A_ENHI:  en_q[NSRC-1:WORD]  <= wdata;
                A_ENLO:  en_q[WORD-1:0]     <= wdata;
                A_TYHI:  typ_q[NSRC-1:WORD] <= wdata;
                A_TYLO:  typ_q[WORD-1:0]    <= wdata;
                A_FRCHI: frc_q[NSRC-1:WORD] <= wdata;
                A_FRCLO: frc_q[WORD-1:0]    <= wdata;
                default: begin
                    if (is_prio_addr(addr))
                        prio_q[WORD*int'(prio_slot(addr)) +: WORD] <= wdata;
                end
            endcase
        end
    end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int N  = 64,
    parameter int PW = 4
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] lvl,
    output logic            valid,
    output logic [$clog2(N)-1:0] id,
    output logic [PW-1:0]   best
);
    localparam int IDW   = $clog2(N);
    localparam int NODES = 2 * N;

    logic           leaf_v [N];
    logic [PW-1:0]  leaf_l [N];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign leaf_v[i] = req[i];
        assign leaf_l[i] = lvl[i*PW +: PW];
    end

    logic           nv  [1:NODES-1];
    logic [IDW-1:0] nid [1:NODES-1];
    logic [PW-1:0]  nl  [1:NODES-1];

    // heap-ordered tree: node k has children 2k (lower numbers) and 2k+1
    always_comb begin
        logic take_hi;
        for (int i = 0; i < N; i++) begin
            nv[N+i]  = leaf_v[i];
            nid[N+i] = IDW'(i);
            nl[N+i]  = leaf_l[i];
        end
        for (int k = N - 1; k >= 1; k--) begin
            take_hi = nv[2*k+1] && (!nv[2*k] || (nl[2*k+1] >= nl[2*k]));
            nv[k]   = nv[2*k] || nv[2*k+1];
            nid[k]  = take_hi ? nid[2*k+1] : nid[2*k];
            nl[k]   = take_hi ? nl[2*k+1]  : nl[2*k];
        end
    end

    assign valid = nv[1];
    assign id    = nid[1];
    assign best  = nl[1];
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       src,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              nirq,
    output logic              firq
);
    logic [WORD-1:0]        ctl_q;
    logic [MASK_W-1:0]      thr_q;
    logic [NSRC-1:0]        en_q, typ_q, frc_q;
    logic [NSRC*PRIO_W-1:0] prio_q;

    intc_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ctl_q  (ctl_q),
        .thr_q  (thr_q),
        .en_q   (en_q),
        .typ_q  (typ_q),
        .frc_q  (frc_q),
        .prio_q (prio_q)
    );

    logic [NSRC-1:0] active, npend, fpend, elig;
    assign active = (src | frc_q) & en_q;
    assign npend  = active & ~typ_q;
    assign fpend  = active & typ_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign elig[i] = npend[i] &&
                         (MASK_W'(prio_q[i*PRIO_W +: PRIO_W]) > thr_q);
    end

    win_t nwin, fwin;

    intc_arb #(.N(NSRC), .PW(PRIO_W)) u_narb (
        .req   (elig),
        .lvl   (prio_q),
        .valid (nwin.valid),
        .id    (nwin.id),
        .best  (nwin.lvl)
    );

    // equal levels everywhere: the tie rule picks the highest number
    intc_arb #(.N(NSRC), .PW(PRIO_W)) u_farb (
        .req   (fpend),
        .lvl   ({(NSRC*PRIO_W){1'b0}}),
        .valid (fwin.valid),
        .id    (fwin.id),
        .best  (fwin.lvl)
    );

    logic [WORD-1:0] nvec_word, fvec_word;
    assign nvec_word = vec_word(nwin);
    assign fvec_word = vec_word('{valid: fwin.valid, id: fwin.id, lvl: '0});

    assign nirq = nwin.valid;
    assign firq = |fpend;

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                A_CTL:   bus_rdata = ctl_q;
                A_THR:   bus_rdata = WORD'(thr_q);
                A_ENHI:  bus_rdata = en_q[NSRC-1:WORD];
                A_ENLO:  bus_rdata = en_q[WORD-1:0];
                A_TYHI:  bus_rdata = typ_q[NSRC-1:WORD];
                A_TYLO:  bus_rdata = typ_q[WORD-1:0];
                A_NVEC:  bus_rdata = nvec_word;
                A_FVEC:  bus_rdata = fvec_word;
                A_RAWHI: bus_rdata = src[NSRC-1:WORD];
                A_RAWLO: bus_rdata = src[WORD-1:0];
                A_FRCHI: bus_rdata = frc_q[NSRC-1:WORD];
                A_FRCLO: bus_rdata = frc_q[WORD-1:0];
                A_NPHI:  bus_rdata = npend[NSRC-1:WORD];
                A_NPLO:  bus_rdata = npend[WORD-1:0];
                A_FPHI:  bus_rdata = fpend[NSRC-1:WORD];
                A_FPLO:  bus_rdata = fpend[WORD-1:0];
                default: begin
                    if (is_prio_addr(bus_addr))
                        bus_rdata = prio_q[WORD*int'(prio_slot(bus_addr)) +: WORD];
                end
            endcase
        end
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD-1:0]   bus_wdata,
    input logic [NSRC-1:0]   src,
    input logic [NSRC-1:0]   en,
    input logic [NSRC-1:0]   typ,
    input logic [MASK_W-1:0] thr,
    input logic              nirq,
    input logic              firq,
    input logic [WORD-1:0]   nv_word
);
    logic [ID_W-1:0] last_num;
    always_ff @(posedge clk) last_num <= bus_wdata[ID_W-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!nirq && !firq)); // R1

    AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ENSET && bus_wdata < WORD'(NSRC)) |=> en[last_num]); // R3

    AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ENCLR && bus_wdata < WORD'(NSRC)) |=> !en[last_num]); // R3

    AST_THR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (thr == THR_RST) |-> !nirq); // R7

    AST_NIRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        nirq |-> |(en & ~typ)); // R8

    AST_FIRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        firq |-> |(en & typ)); // R8

    AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_we) && $stable(src)) |-> $stable(nv_word)); // R10
endmodule

bind intc_top intc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src       (src),
    .en        (en_q),
    .typ       (typ_q),
    .thr       (thr_q),
    .nirq      (nirq),
    .firq      (firq),
    .nv_word   (nvec_word)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    import intc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        nirq, firq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench-side copies of what was written
    logic [63:0] m_en, m_typ, m_frc;
    logic [3:0]  m_prio [64];
    logic [4:0]  m_thr;

    always #5 clk = ~clk;

    intc_top dut (
        .clk(clk), .rst(rst), .src(src), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_re(re), .bus_rdata(rdata), .nirq(nirq), .firq(firq)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #1;
        d = rdata;
        re = 1'b0;
    endtask

    task automatic rdchk(input string rq, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(rq, v, exp);
    endtask

    function automatic logic [31:0] prio_word(input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) w[4*k +: 4] = m_prio[8*n + k];
        return w;
    endfunction

    function automatic logic [6:0] prio_addr(input int n);
        return 7'(32 + 4 * (7 - n));
    endfunction

    function automatic logic [31:0] exp_nvec();
        int bi = -1;
        int bp = -1;
        for (int i = 63; i >= 0; i--) begin
            if (m_en[i] && !m_typ[i] && (src[i] || m_frc[i]) &&
                int'(m_prio[i]) > int'(m_thr) && int'(m_prio[i]) > bp) begin
                bi = i; bp = int'(m_prio[i]);
            end
        end
        if (bi < 0) return 32'hFFFF0000;
        return {16'(bi), 16'(bp)};
    endfunction

    function automatic logic [31:0] exp_fvec();
        for (int i = 63; i >= 0; i--)
            if (m_en[i] && m_typ[i] && (src[i] || m_frc[i])) return {16'(i), 16'h0};
        return 32'hFFFF0000;
    endfunction

    task automatic model_clear();
        m_en = '0; m_typ = '0; m_frc = '0; m_thr = 5'h1F;
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
    endtask

    task automatic push_all();
        wr(A_ENLO, m_en[31:0]);   wr(A_ENHI, m_en[63:32]);
        wr(A_TYLO, m_typ[31:0]);  wr(A_TYHI, m_typ[63:32]);
        wr(A_FRCLO, m_frc[31:0]); wr(A_FRCHI, m_frc[63:32]);
        wr(A_THR, 32'(m_thr));
        for (int n = 0; n < 8; n++) wr(prio_addr(n), prio_word(n));
    endtask

    task automatic check_all(input string rq);
        logic [63:0] act = (src | m_frc) & m_en;
        logic [63:0] np = act & ~m_typ;
        logic [63:0] fp = act & m_typ;
        logic [31:0] nv = exp_nvec();
        rdchk({rq, " R6 nvec"}, A_NVEC, nv);
        rdchk({rq, " R9 fvec"}, A_FVEC, exp_fvec());
        rdchk({rq, " R5 npend lo"}, A_NPLO, np[31:0]);
        rdchk({rq, " R5 npend hi"}, A_NPHI, np[63:32]);
        rdchk({rq, " R5 fpend lo"}, A_FPLO, fp[31:0]);
        rdchk({rq, " R5 fpend hi"}, A_FPHI, fp[63:32]);
        chk({rq, " R8 nirq"}, 32'(nirq), 32'(nv != 32'hFFFF0000));
        chk({rq, " R8 firq"}, 32'(firq), 32'(|fp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v1, v2, v3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();

        // R1 reset values
        rdchk("R1 ctl", A_CTL, 32'h0);
        rdchk("R1 thr", A_THR, 32'h1F);
        rdchk("R1 en lo", A_ENLO, 32'h0);
        rdchk("R1 en hi", A_ENHI, 32'h0);
        rdchk("R1 typ lo", A_TYLO, 32'h0);
        rdchk("R1 typ hi", A_TYHI, 32'h0);
        rdchk("R1 frc lo", A_FRCLO, 32'h0);
        for (int n = 0; n < 8; n++) rdchk("R1 prio", prio_addr(n), 32'h0);
        rdchk("R1 nvec", A_NVEC, 32'hFFFF0000);
        rdchk("R1 fvec", A_FVEC, 32'hFFFF0000);
        chk("R1 nirq", 32'(nirq), 0);
        chk("R1 firq", 32'(firq), 0);

        // R2 readback of split words and control
        wr(A_CTL, 32'hDEADBEEF);   rdchk("R2 ctl", A_CTL, 32'hDEADBEEF);
        wr(A_ENLO, 32'hA5A50001);  rdchk("R2 en lo", A_ENLO, 32'hA5A50001);
        wr(A_ENHI, 32'h800000FF);  rdchk("R2 en hi", A_ENHI, 32'h800000FF);
        wr(A_TYLO, 32'h12345678);  rdchk("R2 typ lo", A_TYLO, 32'h12345678);
        wr(A_TYHI, 32'h9ABCDEF0);  rdchk("R2 typ hi", A_TYHI, 32'h9ABCDEF0);
        wr(A_FRCLO, 32'h0F0F0F0F); rdchk("R2 frc lo", A_FRCLO, 32'h0F0F0F0F);
        wr(A_FRCHI, 32'hF0F0F0F0); rdchk("R2 frc hi", A_FRCHI, 32'hF0F0F0F0);
        // R4 priority slots read back
        for (int n = 0; n < 8; n++) wr(prio_addr(n), 32'h11111111 * (n + 1));
        for (int n = 0; n < 8; n++) rdchk("R4 prio readback", prio_addr(n), 32'h11111111 * (n + 1));

        model_clear();
        push_all();
        // R4 field position: source 1 in register 0 (offset 0x3C) bits 7:4; R2 high word bit 3 is source 35
        wr(7'h3C, 32'h00000090);
        wr(A_THR, 32'h0);
        m_thr = 0; m_prio[1] = 4'd9;
        wr(A_ENSET, 32'd1);  m_en[1] = 1'b1;
        src[1] = 1'b1;
        rdchk("R4 source 1 level", A_NVEC, {16'd1, 16'd9});
        src[1] = 1'b0;
        wr(A_ENSET, 32'd35); m_en[35] = 1'b1;
        wr(A_FRCHI, 32'h8);  m_frc[35] = 1'b1;
        rdchk("R2 force hi bit3 pending", A_NPHI, 32'h8);
        wr(A_FRCHI, 32'h0);  m_frc[35] = 1'b0;

        // sweep every source: R3 number enable/disable, R5, R6, R9
        model_clear();
        m_thr = 0;
        for (int i = 0; i < 64; i++) m_prio[i] = 4'((i % 15) + 1);
        push_all();
        rdchk("R3 enset reads 0", A_ENSET, 32'h0);
        rdchk("R3 enclr reads 0", A_ENCLR, 32'h0);
        for (int i = 0; i < 64; i++) begin
            wr(A_ENSET, 32'(i)); m_en[i] = 1'b1;
            src = 64'h1 << i;
            #1;
            rdchk("R3 R6 single normal", A_NVEC, {16'(i), 16'(m_prio[i])});
            rdchk("R5 raw lo", A_RAWLO, src[31:0]);
            chk("R8 nirq single", 32'(nirq), 1);
            m_typ[i] = 1'b1;
            if (i < 32) wr(A_TYLO, m_typ[31:0]); else wr(A_TYHI, m_typ[63:32]);
            rdchk("R9 single fast", A_FVEC, {16'(i), 16'h0});
            chk("R8 firq single", 32'(firq), 1);
            rdchk("R6 none after steer", A_NVEC, 32'hFFFF0000);
            m_typ[i] = 1'b0;
            if (i < 32) wr(A_TYLO, m_typ[31:0]); else wr(A_TYHI, m_typ[63:32]);
            wr(A_ENCLR, 32'(i)); m_en[i] = 1'b0;
            check_all("R3 disabled");
        end
        src = '0;

        // R3 out-of-range numbers ignored
        wr(A_ENSET, 32'd64);
        wr(A_ENSET, 32'h00000105);
        rdchk("R3 ignore set lo", A_ENLO, 32'h0);
        rdchk("R3 ignore set hi", A_ENHI, 32'h0);
        wr(A_ENLO, 32'hFFFFFFFF); m_en[31:0] = '1;
        wr(A_ENCLR, 32'd96);
        rdchk("R3 ignore clr", A_ENLO, 32'hFFFFFFFF);

        // R6 tie goes to the higher number
        model_clear(); m_thr = 0;
        m_prio[10] = 7; m_prio[20] = 7; m_prio[40] = 7; m_prio[50] = 6;
        m_en[10] = 1; m_en[20] = 1; m_en[40] = 1; m_en[50] = 1;
        push_all();
        src = '0; src[10] = 1; src[20] = 1; src[40] = 1; src[50] = 1;
        #1;
        rdchk("R6 tie", A_NVEC, {16'd40, 16'd7});
        // R6 threshold strict
        wr(A_THR, 32'd7); m_thr = 7;
        rdchk("R6 strict threshold", A_NVEC, 32'hFFFF0000);
        wr(A_THR, 32'd6); m_thr = 6;
        rdchk("R6 above threshold", A_NVEC, {16'd40, 16'd7});

        // R10 reads do not clear, dropping the line removes it
        rd(A_NVEC, v1); rd(A_NVEC, v2); rd(A_NVEC, v3);
        chk("R10 reread 2", v2, v1);
        chk("R10 reread 3", v3, v1);
        src[40] = 1'b0;
        #1;
        rdchk("R10 line dropped", A_NVEC, {16'd20, 16'd7});

        // R7 threshold keeps five bits and blocks all at 0x1F
        wr(A_THR, 32'hFFFFFFFF); m_thr = 5'h1F;
        rdchk("R7 thr width", A_THR, 32'h1F);
        chk("R7 nirq blocked", 32'(nirq), 0);
        rdchk("R7 nvec blocked", A_NVEC, 32'hFFFF0000);

        // R11 unmapped, read-only and strobe gating
        wr(A_THR, 32'd0); m_thr = 0;
        rdchk("R11 unmapped 0x68", 7'h68, 32'h0);
        rdchk("R11 unmapped 0x7C", 7'h7C, 32'h0);
        wr(A_RAWLO, 32'hFFFFFFFF);
        rdchk("R11 raw read-only", A_RAWLO, src[31:0]);
        wr(A_NVEC, 32'h00000000);
        rdchk("R11 nvec read-only", A_NVEC, exp_nvec());
        addr = A_ENLO; re = 1'b0;
        #1;
        chk("R11 rdata gated", rdata, 32'h0);

        // R12 write latency and same-cycle source response
        model_clear(); m_thr = 0; m_prio[5] = 3;
        push_all();
        src = '0; src[5] = 1'b1;
        @(negedge clk);
        addr = A_ENSET; wdata = 32'd5; we = 1'b1;
        #1;
        chk("R12 before edge", 32'(nirq), 0);
        @(negedge clk);
        we = 1'b0; m_en[5] = 1'b1;
        #1;
        chk("R12 after edge", 32'(nirq), 1);
        src[5] = 1'b0;
        #1;
        chk("R12 same cycle drop", 32'(nirq), 0);

        // randomized patterns against the scan model
        for (int t = 0; t < 250; t++) begin
            m_en  = {$urandom, $urandom};
            m_typ = {$urandom, $urandom} & {$urandom, $urandom};
            m_frc = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            m_thr = 5'($urandom % 17);
            for (int i = 0; i < 64; i++) m_prio[i] = 4'($urandom);
            push_all();
            src = {$urandom, $urandom} & {$urandom, $urandom};
            #1;
            check_all("random R5 R6 R8 R9");
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule